// File: doc/BRIEF.md
# Multi-Register Block Transfer Sequencer

This block moves a selected set of registers between a sixteen-entry register file and memory in one operation. Entries 0 to 7 are the data registers D0 to D7 and entries 8 to 15 are the address registers A0 to A7. A start pulse supplies a 16-bit selection mask, a direction, an operand size, an addressing mode, a starting effective address and the index of the address register that serves as the base. The sequencer then makes one memory access for each selected register and steps the address after each one.

Three addressing modes are supported. Plain (control) mode walks upward from the effective address. Predecrement mode stores downward from just below the effective address, with the mask bit order and the walk order reversed. Postincrement mode loads upward. In the last two modes the final address is written back to the base register. Word loads are sign-extended. The base register follows its own rules when it is part of the list. Illegal mode and direction pairs are rejected with an error flag.

Top module: `blkxfer_seq`

## Requirements
- R1: Only registers whose mask bit is set are transferred, and each makes exactly one memory access. Unselected registers cause no access, so the access count equals the number of set mask bits.
- R2: `lng`=0 selects 16-bit words with a step of 2, and `lng`=1 selects 32-bit longs with a step of 4. `mem_long` reflects the size on every access. A word store puts the low 16 bits of the register on `mem_wdata[15:0]`, with bits 31:16 at zero.
- R3: In plain mode (`mode`=0) and postincrement mode (`mode`=2), mask bit i selects register entry i. Accesses go in ascending entry order. Access j uses address `ea` + j*step.
- R4: In predecrement mode (`mode`=1), mask bit k selects register entry 15-k, so bit 0 is A7 and bit 15 is D0. Accesses go in descending entry order. Access j uses address `ea` - (j+1)*step.
- R5: After a predecrement operation, entry 8+`areg` holds the address of the last operand stored. After a postincrement operation, it holds `ea` + n*step, where n is the number of transfers.
- R6: In postincrement mode, if the base register is in the list, its loaded memory value is discarded and it receives the final address.
- R7: A word load writes the 16-bit value sign-extended to 32 bits, for data and address registers alike. A long load writes all 32 bits.
- R8: In predecrement mode, storing the base register writes its initial value minus the step when parameter PREDEC_STORE_DECR is 1 (the default). When the parameter is 0, the initial value is written unchanged.
- R9: An all-zero mask makes no access and raises `done` in the cycle right after the start cycle. In predecrement and postincrement modes, the base register is written back with `ea`.
- R10: `mem_req` is held with stable address and write flag until `mem_ready`. `done` is a one-cycle pulse in the cycle after the last accepted transfer. A start while busy is ignored. After reset, `busy`, `done`, `err` and `mem_req` are low.
- R11: Predecrement with `dir`=1 (memory to register), postincrement with `dir`=0, and mode 3 are illegal. Each raises `err` together with `done` one cycle after start, with no memory access and no register write.
- R12: Plain mode writes no address back, so the base register is left untouched unless it is itself loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mask | input | 16 | Register selection mask |
| dir | input | 1 | 0 register to memory, 1 memory to register |
| lng | input | 1 | 0 word, 1 long |
| mode | input | 2 | 0 plain, 1 predecrement, 2 postincrement, 3 illegal |
| ea | input | 32 | Starting effective address |
| areg | input | 3 | Base address register index (entry 8+areg) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal request, valid with done |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a store |
| mem_long | output | 1 | Access is 32 bits wide |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| mem_ready | input | 1 | Access accepted this cycle |

## Verification
The properties assume that the register file answers a read in the same cycle and does not change during an operation except through this block's own write port. They also assume `mem_ready` is only meaningful while `mem_req` is high, and that the request inputs are sampled only in the start cycle. The bench models the register file as a combinational array that is updated only from `rf_we`. Its memory responder raises `mem_ready` only against a live request, after a per-test latency of zero to two cycles. Start is issued only from idle, apart from one deliberate pulse mid-operation that checks it is ignored.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  typedef enum logic [1:0] {
    AM_PLAIN   = 2'd0,
    AM_PREDEC  = 2'd1,
    AM_POSTINC = 2'd2,
    AM_RSVD    = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/blkxfer_pick.sv
// Finds the lowest and highest set entries of a pending vector in one cycle.
module blkxfer_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] lo,
  output logic [IW-1:0] hi
);
  always_comb begin
    lo = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) lo = IW'(i);
    end
  end

  always_comb begin
    hi = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) hi = IW'(i);
    end
  end
endmodule

// File: rtl/blkxfer_fmt.sv
// Store narrowing and load sign extension for the operand size.
module blkxfer_fmt #(
  parameter int DW = 32,
  parameter int HW = 16
) (
  input  logic          lng,
  input  logic [DW-1:0] st_src,
  input  logic [DW-1:0] ld_raw,
  output logic [DW-1:0] st_data,
  output logic [DW-1:0] ld_data
);
  function automatic logic [DW-1:0] sext_half(input logic [DW-1:0] v);
    return {{(DW-HW){v[HW-1]}}, v[HW-1:0]};
  endfunction

  function automatic logic [DW-1:0] zext_half(input logic [DW-1:0] v);
    return {{(DW-HW){1'b0}}, v[HW-1:0]};
  endfunction

  assign st_data = lng ? st_src : zext_half(st_src);
  assign ld_data = lng ? ld_raw : sext_half(ld_raw);
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int NREG              = 16,
  parameter int AW                = 32,
  parameter int DW                = 32,
  parameter bit PREDEC_STORE_DECR = 1'b1,
  localparam int IW  = $clog2(NREG),
  localparam int AIW = IW - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NREG-1:0] mask,
  input  logic            dir,
  input  logic            lng,
  input  logic [1:0]      mode,
  input  logic [AW-1:0]   ea,
  input  logic [AIW-1:0]  areg,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [IW-1:0]   rf_raddr,
  input  logic [DW-1:0]   rf_rdata,
  output logic            rf_we,
  output logic [IW-1:0]   rf_waddr,
  output logic [DW-1:0]   rf_wdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_long,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ready
);
  localparam int HALF = NREG / 2;

  function automatic logic [AW-1:0] op_len(input logic l);
    return l ? AW'(4) : AW'(2);
  endfunction

  function automatic logic [AW-1:0] access_addr(input logic [AW-1:0] c,
                                                input logic [AW-1:0] step,
                                                input logic pre);
    return pre ? c - step : c;
  endfunction

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] c,
                                              input logic [AW-1:0] step,
                                              input logic pre);
    return pre ? c - step : c + step;
  endfunction

  seq_state_e       state_q;
  logic [NREG-1:0]  pend_q;
  logic [NREG-1:0]  pend_clr;
  logic [NREG-1:0]  mask_rev;
  logic [NREG-1:0]  mask_canon;
  logic [AW-1:0]    cur_q;
  logic             dir_q;
  logic             lng_q;
  logic             err_q;
  amode_e           mode_q;
  amode_e           mode_in;
  logic [AIW-1:0]   areg_q;

  logic [IW-1:0]    lo_idx;
  logic [IW-1:0]    hi_idx;
  logic [IW-1:0]    sel_idx;
  logic [IW-1:0]    base_idx;
  logic             is_pre;
  logic             sel_is_base;
  logic [AW-1:0]    len;

  // named events
  logic             start_acc;
  logic             illegal_in;
  logic             xfer_fire;
  logic             last_xfer;
  logic             fin_evt;
  logic             load_wr;
  logic             wb_wr;

  logic [DW-1:0]    st_src;
  logic [DW-1:0]    st_data;
  logic [DW-1:0]    ld_data;

  for (genvar g = 0; g < NREG; g++) begin : g_rev
    assign mask_rev[g] = mask[NREG-1-g];
  end

  assign mode_in    = amode_e'(mode);
  assign start_acc  = start && (state_q == ST_IDLE);
  assign illegal_in = (mode_in == AM_RSVD) ||
                      (mode_in == AM_PREDEC && dir) ||
                      (mode_in == AM_POSTINC && !dir);
  assign mask_canon = (mode_in == AM_PREDEC) ? mask_rev : mask;

  blkxfer_pick #(.N(NREG), .IW(IW)) u_pick (
    .vec (pend_q),
    .lo  (lo_idx),
    .hi  (hi_idx)
  );

  assign is_pre      = (mode_q == AM_PREDEC);
  assign sel_idx     = is_pre ? hi_idx : lo_idx;
  assign base_idx    = IW'(HALF) + IW'(areg_q);
  assign sel_is_base = (sel_idx == base_idx);
  assign len         = op_len(lng_q);

  always_comb begin
    pend_clr          = pend_q;
    pend_clr[sel_idx] = 1'b0;
  end

  assign xfer_fire = (state_q == ST_XFER) && mem_ready;
  assign last_xfer = (pend_clr == '0);
  assign fin_evt   = (state_q == ST_FIN);
  assign load_wr   = xfer_fire && dir_q && !((mode_q == AM_POSTINC) && sel_is_base);
  assign wb_wr     = fin_evt && !err_q && (mode_q != AM_PLAIN);

  assign st_src = (is_pre && sel_is_base && PREDEC_STORE_DECR) ? rf_rdata - DW'(len)
                                                              : rf_rdata;

  blkxfer_fmt #(.DW(DW), .HW(DW/2)) u_fmt (
    .lng     (lng_q),
    .st_src  (st_src),
    .ld_raw  (mem_rdata),
    .st_data (st_data),
    .ld_data (ld_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      cur_q   <= '0;
      dir_q   <= 1'b0;
      lng_q   <= 1'b0;
      err_q   <= 1'b0;
      mode_q  <= AM_PLAIN;
      areg_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_acc) begin
            dir_q   <= dir;
            lng_q   <= lng;
            mode_q  <= mode_in;
            areg_q  <= areg;
            cur_q   <= ea;
            err_q   <= illegal_in;
            pend_q  <= illegal_in ? '0 : mask_canon;
            state_q <= (illegal_in || mask_canon == '0) ? ST_FIN : ST_XFER;
          end
        end
        ST_XFER: begin
          if (mem_ready) begin
            pend_q <= pend_clr;
            cur_q  <= step_addr(cur_q, len, is_pre);
            if (last_xfer) state_q <= ST_FIN;
          end
        end
        ST_FIN: begin
          err_q   <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = fin_evt;
  assign err       = fin_evt && err_q;
  assign mem_req   = (state_q == ST_XFER);
  assign mem_we    = mem_req && !dir_q;
  assign mem_long  = lng_q;
  assign mem_addr  = access_addr(cur_q, len, is_pre);
  assign mem_wdata = mem_we ? st_data : '0;
  assign rf_raddr  = sel_idx;
  assign rf_we     = load_wr || wb_wr;
  assign rf_waddr  = fin_evt ? base_idx : sel_idx;
  assign rf_wdata  = fin_evt ? DW'(cur_q) : ld_data;
endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic [NREG-1:0] mask,
  input logic            dir,
  input logic [1:0]      mode,
  input logic            done,
  input logic            err,
  input logic            mem_req,
  input logic            mem_ready,
  input logic            mem_we,
  input logic            mem_long,
  input logic [AW-1:0]   mem_addr,
  input logic [DW-1:0]   mem_wdata
);
  logic req_illegal;
  logic take;
  assign req_illegal = (mode == 2'd3) || (mode == 2'd1 && dir) || (mode == 2'd2 && !dir);
  assign take        = start && !busy;

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_ZERO_MASK_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
    take && mask == '0 |=> done && !mem_req); // R9
  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_illegal |=> done && err && !mem_req); // R11
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R11
  AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_long |-> mem_wdata[DW-1:DW/2] == '0); // R2
endmodule

bind blkxfer_seq blkxfer_seq_chk #(.NREG(NREG), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .mask      (mask),
  .dir       (dir),
  .mode      (mode),
  .done      (done),
  .err       (err),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_long  (mem_long),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/blkxfer_seq_tb.sv
module blkxfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] mask = '0;
  logic        dir = 1'b0;
  logic        lng = 1'b0;
  logic [1:0]  mode = '0;
  logic [31:0] ea = '0;
  logic [2:0]  areg = '0;
  logic        busy, done, err;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata;
  logic        rf_we;
  logic        mem_req, mem_we, mem_long;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  logic [31:0] regs [16];
  logic [31:0] expr [16];
  logic [31:0] log_addr [32];
  logic [31:0] log_wd [32];
  logic        log_we [32];
  logic        log_lg [32];
  int nlog, lat, wcnt, tcount, last_rdy;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  assign rf_rdata = regs[rf_raddr];

  blkxfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mask(mask), .dir(dir), .lng(lng),
    .mode(mode), .ea(ea), .areg(areg), .busy(busy), .done(done), .err(err),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_we(mem_we), .mem_long(mem_long),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  function automatic logic [31:0] memval(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[1] ^ a[2], a[14:0] ^ 15'h300F};
  endfunction

  function automatic logic [31:0] initv(input int i);
    return 32'h1000_0000 * i + 32'h0000_8000 * (i % 2) + 32'h111 * i + 32'h7;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    tcount++;
    if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ready = 1'b1;
        mem_rdata = memval(mem_addr);
        if (nlog < 32) begin
          log_addr[nlog] = mem_addr;
          log_wd[nlog]   = mem_wdata;
          log_we[nlog]   = mem_we;
          log_lg[nlog]   = mem_long;
        end
        nlog++;
        last_rdy = tcount;
        wcnt = 0;
      end else begin
        mem_ready = 1'b0;
        wcnt++;
      end
    end else begin
      mem_ready = 1'b0;
      wcnt = 0;
    end
    #1;
    if (rf_we) regs[rf_waddr] = rf_wdata;
  endtask

  // Runs one operation and checks every access and the final register file.
  task automatic run_op(input logic [15:0] m, input bit d, input bit l,
                        input logic [1:0] md, input logic [31:0] e,
                        input logic [2:0] ar, input int lt, input bit poke,
                        input string rq);
    int cyc, n, r;
    bit pre, ill, got_err;
    logic [31:0] step, a, xd;
    for (int i = 0; i < 16; i++) begin
      regs[i] = initv(i);
      expr[i] = initv(i);
    end
    nlog = 0; lat = lt; wcnt = 0; last_rdy = -1;
    pre = (md == 2'd1);
    ill = (md == 2'd3) || (md == 2'd1 && d) || (md == 2'd2 && !d);
    step = l ? 32'd4 : 32'd2;
    mask = m; dir = d; lng = l; mode = md; ea = e; areg = ar;
    start = 1'b1;
    tick();
    start = 1'b0;
    cyc = 1;
    if (poke && !done) begin
      mask = ~m; dir = ~d; mode = 2'd0; ea = e + 32'h100; start = 1'b1;
      tick(); cyc++;
      start = 1'b0;
    end
    while (!done && cyc < 300) begin
      tick(); cyc++;
    end
    got_err = err;
    chk(done == 1'b1, "R10", "done seen", 32'(done), 32'd1);
    chk(got_err == ill, "R11", "err flag", 32'(got_err), 32'(ill));
    if (ill || m == 16'h0)
      chk(cyc == 1, ill ? "R11" : "R9", "cycles to done", cyc, 1);
    else
      chk(tcount == last_rdy + 1, "R10", "done after last ready", tcount, last_rdy + 1);
    n = 0;
    if (!ill) begin
      for (int k = 0; k < 16; k++) begin
        if (m[k]) begin
          r = pre ? 15 - k : k;
          a = pre ? e - step * (n + 1) : e + step * n;
          if (n < 32) begin
            chk(log_addr[n] == a, pre ? "R4" : "R3", "access address", log_addr[n], a);
            chk(log_we[n] == !d && log_lg[n] == l, "R2", "access kind",
                {30'd0, log_we[n], log_lg[n]}, {30'd0, !d, l});
            if (!d) begin
              xd = initv(r);
              if (pre && r == 8 + ar) xd = xd - step;
              if (!l) xd = {16'h0, xd[15:0]};
              chk(log_wd[n] == xd, (pre && r == 8 + ar) ? "R8" : "R2", "store data",
                  log_wd[n], xd);
            end else if (!(md == 2'd2 && r == 8 + ar)) begin
              xd = memval(a);
              expr[r] = l ? xd : {{16{xd[15]}}, xd[15:0]};
            end
          end
          n++;
        end
      end
      if (md == 2'd1) expr[8 + ar] = e - step * n;
      if (md == 2'd2) expr[8 + ar] = e + step * n;
    end
    chk(nlog == n, "R1", "access count", nlog, n);
    for (int i = 0; i < 16; i++)
      chk(regs[i] == expr[i], rq, $sformatf("register %0d", i), regs[i], expr[i]);
    tick();
    chk(done == 1'b0 && busy == 1'b0, "R10", "done single pulse", {30'd0, done, busy}, 32'd0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !mem_req, "R10", "reset outputs",
        {28'd0, busy, done, err, mem_req}, 32'd0);
  endtask

  task automatic t_plain_store_long();    // R1 R3 R2 R12
    run_op(16'h8181, 1'b0, 1'b1, 2'd0, 32'h0000_2000, 3'd3, 1, 1'b0, "R12");
  endtask

  task automatic t_plain_load_word();     // R7 R3
    run_op(16'h0F30, 1'b1, 1'b0, 2'd0, 32'h0000_3FFC, 3'd1, 0, 1'b0, "R7");
  endtask

  task automatic t_predec_word_base();    // R4 R5 R8, A2 is mask bit 5
    run_op(16'h8023, 1'b0, 1'b0, 2'd1, 32'h0000_4000, 3'd2, 0, 1'b0, "R5");
  endtask

  task automatic t_predec_long_all();     // R4 R5 R8
    run_op(16'hFFFF, 1'b0, 1'b1, 2'd1, 32'h0001_0000, 3'd7, 2, 1'b0, "R5");
  endtask

  task automatic t_postinc_long_base();   // R6 R5, A4 in list
    run_op(16'h1003, 1'b1, 1'b1, 2'd2, 32'h0000_6000, 3'd4, 1, 1'b0, "R6");
  endtask

  task automatic t_postinc_word();        // R7 R5
    run_op(16'h00F0, 1'b1, 1'b0, 2'd2, 32'h0000_7FFA, 3'd0, 0, 1'b0, "R7");
  endtask

  task automatic t_zero_mask();           // R9
    run_op(16'h0000, 1'b0, 1'b1, 2'd1, 32'h0000_5000, 3'd5, 0, 1'b0, "R9");
    run_op(16'h0000, 1'b1, 1'b0, 2'd2, 32'h0000_5100, 3'd6, 0, 1'b0, "R9");
  endtask

  task automatic t_illegal();             // R11
    run_op(16'h00FF, 1'b1, 1'b1, 2'd1, 32'h0000_8000, 3'd1, 0, 1'b0, "R11");
    run_op(16'hFF00, 1'b0, 1'b0, 2'd2, 32'h0000_8100, 3'd2, 0, 1'b0, "R11");
    run_op(16'h0101, 1'b0, 1'b1, 2'd3, 32'h0000_8200, 3'd3, 0, 1'b0, "R11");
  endtask

  task automatic t_busy_start();          // R10
    run_op(16'h0C06, 1'b1, 1'b1, 2'd0, 32'h0000_9000, 3'd0, 2, 1'b1, "R10");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = initv(i);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_plain_store_long();
    t_plain_load_word();
    t_predec_word_base();
    t_predec_long_all();
    t_postinc_long_base();
    t_postinc_word();
    t_zero_mask();
    t_illegal();
    t_busy_start();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule